// File: doc/BRIEF.md
# Configuration-Record Name Finder

This block scans a byte buffer of tagged configuration records and pulls out the 64-bit world-wide name stored in it. A pulse on `start` begins the scan. The block then reads the buffer through a synchronous memory read port, taking one byte per clock cycle, and works through the small and large records in order. Inside one large record type it descends into subfields. When a subfield carries the name tag, the block captures the eight name bytes and records the buffer index of the first one.

Every byte is read in address order and consumed as it arrives. The walk never jumps addresses, so any record length costs one cycle per byte. The scan ends at the end-marker record or after the last buffer index. Once any name capture in progress is complete, `done` rises and stays high until the next `start`. At that point `found`, `name_offset` and `name_value` hold the result.

Top module: `nv_name_finder`

## Requirements
- R1: After reset, `done` and `found` are low and both `name_offset` and `name_value` are zero.
- R2: A header byte with bit 7 clear is a small record. Its name is bits 6:3 and its total length is 1 plus bits 2:0. The bytes that follow the header inside the record are never interpreted, even if they look like tags.
- R3: A small record named 0xF ends the walk, and no record after it is examined. If this marker is buffer byte 0, `done` rises on the third clock edge after the edge that samples `start`.
- R4: A header byte with bit 7 set is a large record. Its name is bits 6:0 and its total length is 3 plus a 16-bit length held little-endian in the two following bytes. A large record whose name is not 0x0D is skipped whole, without looking at its contents.
- R5: In a large record named 0x0D, if the first byte after the three-byte header is 0x3B, the record's total length is taken as 6, whatever its length field says.
- R6: In any other 0x0D record, the body is a chain of subfields. Each subfield starts with a tag byte whose name is the low 6 bits, followed by a 16-bit little-endian length. The next tag is 3 plus that length bytes further on, and the chain continues while the tag lies inside the record. For tag name 0x3C, the 8 bytes after the subfield's 3-byte header become `name_value`, with the first byte in bits 63:56. `name_offset` is the buffer index of that first byte, and `found` goes high.
- R7: When several 0x3C subfields appear, the last one in the buffer sets `name_value` and `name_offset`.
- R8: When no 0x3C subfield is found, `found` is low and both `name_offset` and `name_value` are zero.
- R9: Record headers are interpreted only at buffer index 127 or lower. Any byte at index 128 or above, including name bytes captured there, reads as zero.
- R10: `start` clears `done`, `found`, `name_offset` and `name_value` on the edge that samples it, and restarts the walk from index 0. `done` then stays high from the end of the scan until the next `start`.
- R11: `mem_addr` presents 0, 1, 2, ... one per cycle, beginning in the cycle after `start` is sampled. The byte for an address is taken from `mem_rdata` one cycle later. A scan with no end marker reads all 128 buffer bytes, and `done` rises no later than 142 cycles after `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears results and starts a scan |
| mem_addr | output | 7 | Read address to the record buffer |
| mem_rdata | input | 8 | Byte for the previous cycle's address |
| done | output | 1 | Scan complete, held until the next start |
| found | output | 1 | A name subfield was found |
| name_offset | output | 8 | Buffer index of the first name byte, or zero |
| name_value | output | 64 | Captured name, first byte in bits 63:56 |

## Verification
The bench builds the block with its default parameters: a 128-byte buffer and an 8-byte name. These values make the buffer-end boundary reachable. A name subfield placed four bytes before index 128 must take zeros for its last four bytes. The memory wraps its address, so if the zero-fill were missing, nonzero bytes from the start of the buffer would show up in the name instead. The same sizes allow a scan with no end marker to be timed against the full-buffer latency bound. They also allow a 0x3B skip record to declare a 64-byte length that, if honoured, would swallow the real name record behind it.

// File: rtl/nv_name_finder_pkg.sv
// Package: shared encodings for the configuration-record name finder.
// Assumes byte-wide records; all constants are format-defined.
package nv_name_finder_pkg;

    typedef enum logic [2:0] {
        W_HDR,   // next byte is a record header
        W_LLO,   // large record length, low byte
        W_LHI,   // large record length, high byte
        W_PEEK,  // first body byte of a searched record
        W_BODY,  // inside a searched record body
        W_SKIP,  // bytes to pass over unread
        W_HALT   // end marker seen
    } walk_st_t;

    typedef enum logic [1:0] {
        S_TAG,
        S_LLO,
        S_LHI,
        S_DAT
    } sub_st_t;

    localparam logic [3:0]  END_NAME    = 4'hF;
    localparam logic [6:0]  SEARCH_REC  = 7'h0D;
    localparam logic [7:0]  SKIP_MARK   = 8'h3B;
    localparam logic [5:0]  NAME_TAG    = 6'h3C;
    localparam int          HDR_BYTES   = 3;
    localparam logic [15:0] SKIP_REST   = 16'd2;

endpackage

// File: rtl/nv_fetch.sv
// Module: sequential byte fetcher.
// Issues buffer addresses 0,1,2,... one per cycle while running and
// presents each returned byte with its index one cycle later. Indices at
// or beyond BUF_BYTES are presented as zero. Assumes a read port with
// exactly one cycle of latency.
module nv_fetch #(
    parameter int BUF_BYTES = 128,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              finish,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              running,
    output logic              byte_vld,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [7:0]        byte_val
);

    logic [IDX_W-1:0] fetch_idx;

    // Address counter and returned-byte tagging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            fetch_idx <= '0;
            byte_vld  <= 1'b0;
            byte_idx  <= '0;
        end else if (start) begin
            running   <= 1'b1;
            fetch_idx <= '0;
            byte_vld  <= 1'b0;
        end else if (finish) begin
            running   <= 1'b0;
            byte_vld  <= 1'b0;
        end else if (running) begin
            fetch_idx <= fetch_idx + 1'b1;
            byte_vld  <= 1'b1;
            byte_idx  <= fetch_idx;
        end
    end

    assign mem_addr = fetch_idx[ADDR_W-1:0];

    // Zero substitution beyond the buffer.
    always_comb begin
        byte_val = (byte_idx < IDX_W'(BUF_BYTES)) ? mem_rdata : 8'h00;
    end

    assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start && !finish) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/nv_walker.sv
// Module: record walker.
// Consumes one byte per valid cycle and tracks where it stands in the
// record chain: small records, large records, the searched large type and
// its subfields. Pulses tag_hit on a name-subfield tag byte. Assumes the
// bytes arrive in index order with no gaps.
module nv_walker
    import nv_name_finder_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int IDX_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_val,
    output logic             tag_hit,
    output logic             halted
);

    walk_st_t st, st_n;
    sub_st_t  sub, sub_n, sub_eff;
    logic [15:0] cnt, cnt_n, scnt, scnt_n, len16, slen16;
    logic [7:0]  llo, llo_n, slo, slo_n;
    logic        is_srch, is_srch_n;
    logic        active, do_hdr, do_sub;

    assign active  = byte_vld && (byte_idx < IDX_W'(BUF_BYTES));
    assign halted  = (st == W_HALT);
    assign len16   = {byte_val, llo};
    assign slen16  = {byte_val, slo};
    assign sub_eff = (st == W_PEEK) ? S_TAG : sub;

    // Next-state decode for the record and subfield walks.
    always_comb begin
        st_n      = st;
        sub_n     = sub;
        cnt_n     = cnt;
        scnt_n    = scnt;
        llo_n     = llo;
        slo_n     = slo;
        is_srch_n = is_srch;
        do_hdr    = 1'b0;
        do_sub    = 1'b0;
        tag_hit   = 1'b0;
        if (active) begin
            case (st)
                W_HDR:  do_hdr = 1'b1;
                W_LLO:  begin llo_n = byte_val; st_n = W_LHI; end
                W_LHI: begin
                    cnt_n = len16;
                    if (is_srch)           st_n = W_PEEK;
                    else if (len16 == '0)  st_n = W_HDR;
                    else                   st_n = W_SKIP;
                end
                W_PEEK: begin
                    if (byte_val == SKIP_MARK) begin
                        cnt_n = SKIP_REST;
                        st_n  = W_SKIP;
                    end else if (cnt == '0) begin
                        do_hdr = 1'b1;
                    end else begin
                        do_sub = 1'b1;
                        cnt_n  = cnt - 16'd1;
                        st_n   = (cnt == 16'd1) ? W_HDR : W_BODY;
                    end
                end
                W_BODY: begin
                    do_sub = 1'b1;
                    cnt_n  = cnt - 16'd1;
                    if (cnt == 16'd1) st_n = W_HDR;
                end
                W_SKIP: begin
                    cnt_n = cnt - 16'd1;
                    if (cnt == 16'd1) st_n = W_HDR;
                end
                default: ;
            endcase
        end
        if (do_hdr) begin
            if (!byte_val[7]) begin
                if (byte_val[6:3] == END_NAME) begin
                    st_n = W_HALT;
                end else if (byte_val[2:0] == 3'd0) begin
                    st_n = W_HDR;
                end else begin
                    cnt_n = {13'd0, byte_val[2:0]};
                    st_n  = W_SKIP;
                end
            end else begin
                is_srch_n = (byte_val[6:0] == SEARCH_REC);
                st_n      = W_LLO;
            end
        end
        if (do_sub) begin
            case (sub_eff)
                S_TAG: begin
                    tag_hit = (byte_val[5:0] == NAME_TAG);
                    sub_n   = S_LLO;
                end
                S_LLO: begin slo_n = byte_val; sub_n = S_LHI; end
                S_LHI: begin
                    scnt_n = slen16;
                    sub_n  = (slen16 == '0) ? S_TAG : S_DAT;
                end
                default: begin
                    scnt_n = scnt - 16'd1;
                    if (scnt == 16'd1) sub_n = S_TAG;
                end
            endcase
        end
    end

    // State registers, cleared by reset or a new scan.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st      <= W_HDR;
            sub     <= S_TAG;
            cnt     <= '0;
            scnt    <= '0;
            llo     <= '0;
            slo     <= '0;
            is_srch <= 1'b0;
        end else begin
            st      <= st_n;
            sub     <= sub_n;
            cnt     <= cnt_n;
            scnt    <= scnt_n;
            llo     <= llo_n;
            slo     <= slo_n;
            is_srch <= is_srch_n;
        end
    end

    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !clr) |=> halted);

endmodule

// File: rtl/nv_capture.sv
// Module: name capture.
// On a tag hit, notes the offset of the first name byte (tag index plus
// the subfield header) and shifts in the NAME_BYTES bytes starting there.
// A later hit restarts the capture, so the last match wins.
module nv_capture
    import nv_name_finder_pkg::*;
#(
    parameter int NAME_BYTES = 8,
    parameter int IDX_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  byte_vld,
    input  logic [IDX_W-1:0]      byte_idx,
    input  logic [7:0]            byte_val,
    input  logic                  tag_hit,
    output logic                  found,
    output logic [IDX_W-1:0]      offset,
    output logic [NAME_BYTES*8-1:0] name,
    output logic                  idle
);

    localparam int NAME_W   = NAME_BYTES * 8;
    localparam int CAP_LOAD = NAME_BYTES + HDR_BYTES - 1;
    localparam int CAP_W    = $clog2(CAP_LOAD + 1);

    logic [CAP_W-1:0] cap_cnt;

    assign idle = (cap_cnt == '0);

    // Capture window countdown and name shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cap_cnt <= '0;
            found   <= 1'b0;
            offset  <= '0;
            name    <= '0;
        end else if (byte_vld) begin
            if (tag_hit) begin
                cap_cnt <= CAP_W'(CAP_LOAD);
                offset  <= byte_idx + IDX_W'(HDR_BYTES);
                found   <= 1'b1;
            end else if (cap_cnt != '0) begin
                if (cap_cnt <= CAP_W'(NAME_BYTES))
                    name <= {name[NAME_W-9:0], byte_val};
                cap_cnt <= cap_cnt - 1'b1;
            end
        end
    end

    assert_offset_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (offset == '0));
    assert_offset_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (offset >= IDX_W'(HDR_BYTES)));
    assert_found_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !clr) |=> found);

endmodule

// File: rtl/nv_name_finder.sv
// Module: configuration-record name finder (top).
// Streams the record buffer through the walker and the capture unit and
// ends the scan once no header can follow (end marker or buffer end) and
// no name capture is still collecting bytes. Assumes start is a pulse.
module nv_name_finder
    import nv_name_finder_pkg::*;
#(
    parameter int BUF_BYTES  = 128,
    parameter int NAME_BYTES = 8,
    parameter int ADDR_W     = $clog2(BUF_BYTES),
    parameter int IDX_W      = $clog2(BUF_BYTES + NAME_BYTES + 8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [7:0]              mem_rdata,
    output logic                    done,
    output logic                    found,
    output logic [IDX_W-1:0]        name_offset,
    output logic [NAME_BYTES*8-1:0] name_value
);

    logic             running, byte_vld, tag_hit, halted, cap_idle, finish;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       byte_val;

    nv_fetch #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .running(running),
        .byte_vld(byte_vld), .byte_idx(byte_idx), .byte_val(byte_val)
    );

    nv_walker #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .clr(start), .byte_vld(byte_vld),
        .byte_idx(byte_idx), .byte_val(byte_val), .tag_hit(tag_hit),
        .halted(halted)
    );

    nv_capture #(.NAME_BYTES(NAME_BYTES), .IDX_W(IDX_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .clr(start), .byte_vld(byte_vld),
        .byte_idx(byte_idx), .byte_val(byte_val), .tag_hit(tag_hit),
        .found(found), .offset(name_offset), .name(name_value),
        .idle(cap_idle)
    );

    // The current byte is not needed by either the walker or the capture.
    assign finish = running && byte_vld && !start && cap_idle &&
                    (halted || (byte_idx >= IDX_W'(BUF_BYTES)));

    // Completion flag, held until the next scan.
    always_ff @(posedge clk) begin
        if (!rst_n || start) done <= 1'b0;
        else if (finish)     done <= 1'b1;
    end

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);
    assert_done_captured_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cap_idle);
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: tb/test_nv_name_finder.sv
module test_nv_name_finder;

    localparam int BUF = 128;
    localparam int NB  = 8;
    localparam int AW  = 7;
    localparam int IW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;
    logic          done, found;
    logic [IW-1:0] name_offset;
    logic [63:0]   name_value;

    logic [7:0]    mem [BUF];
    int            n_chk = 0;
    int            n_bad = 0;
    int            last_cyc;
    logic [AW-1:0] seen_addr [3];
    logic          done_after_start;

    always #4 clk = ~clk;

    always @(posedge clk) mem_rdata <= mem[mem_addr];

    nv_name_finder i_nv_name_finder (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .found(found),
        .name_offset(name_offset), .name_value(name_value)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < BUF; i++) mem[i] = 8'h00;
    endtask

    task automatic put8(input int a, input logic [63:0] d);
        for (int i = 0; i < 8; i++) mem[a+i] = d[63-8*i -: 8];
    endtask

    // Pulse start, record early address/done samples, wait for done.
    task automatic run();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        done_after_start = done;
        seen_addr[0] = mem_addr;
        last_cyc = 1;
        while (!done && last_cyc < 1000) begin
            @(negedge clk);
            if (last_cyc < 3) seen_addr[last_cyc] = mem_addr;
            last_cyc++;
        end
    endtask

    task automatic t_reset();
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 found", {63'd0, found}, 64'd0);
        chk("R1 offset", {56'd0, name_offset}, 64'd0);
        chk("R1 name", name_value, 64'd0);
    endtask

    task automatic t_basic();
        clear_mem();
        mem[0] = 8'h0A; mem[1] = 8'h3C; mem[2] = 8'hFC;
        mem[3] = 8'h8D; mem[4] = 8'h0C; mem[5] = 8'h00;
        mem[6] = 8'h3C; mem[7] = 8'h08; mem[8] = 8'h00;
        put8(9, 64'h1122334455667788);
        mem[18] = 8'h78;
        run();
        chk("R10 done cleared by start", {63'd0, done_after_start}, 64'd0);
        chk("R11 addr0", {57'd0, seen_addr[0]}, 64'd0);
        chk("R11 addr1", {57'd0, seen_addr[1]}, 64'd1);
        chk("R11 addr2", {57'd0, seen_addr[2]}, 64'd2);
        chk("R2 found", {63'd0, found}, 64'd1);
        chk("R6 offset", {56'd0, name_offset}, 64'd9);
        chk("R6 name", name_value, 64'h1122334455667788);
        repeat (5) @(negedge clk);
        chk("R10 done held", {63'd0, done}, 64'd1);
    endtask

    task automatic t_end_marker();
        clear_mem();
        mem[0] = 8'h78;
        mem[1] = 8'h8D; mem[2] = 8'h0B; mem[3] = 8'h00;
        mem[4] = 8'h3C; mem[5] = 8'h08; mem[6] = 8'h00;
        put8(7, 64'hCAFEF00DDEADBEEF);
        run();
        chk("R3 not found after marker", {63'd0, found}, 64'd0);
        chk("R3 stop latency", 64'(last_cyc), 64'd4);
    endtask

    task automatic t_large_skip();
        clear_mem();
        mem[0] = 8'h85; mem[1] = 8'h0B; mem[2] = 8'h00;
        mem[3] = 8'h3C; mem[4] = 8'h08; mem[5] = 8'h00;
        put8(6, 64'h78EEEEEEEEEEEEEE);
        mem[14] = 8'h8D; mem[15] = 8'h0B; mem[16] = 8'h00;
        mem[17] = 8'hFC; mem[18] = 8'h08; mem[19] = 8'h00;
        put8(20, 64'hA1A2A3A4A5A6A7A8);
        mem[28] = 8'h78;
        run();
        chk("R4 offset", {56'd0, name_offset}, 64'd20);
        chk("R4 name", name_value, 64'hA1A2A3A4A5A6A7A8);
    endtask

    task automatic t_override();
        clear_mem();
        mem[0] = 8'h8D; mem[1] = 8'h40; mem[2] = 8'h00;
        mem[3] = 8'h3B; mem[4] = 8'hEE; mem[5] = 8'hEE;
        mem[6] = 8'h8D; mem[7] = 8'h0B; mem[8] = 8'h00;
        mem[9] = 8'h3C; mem[10] = 8'h08; mem[11] = 8'h00;
        put8(12, 64'h0102030405060708);
        mem[20] = 8'h78;
        run();
        chk("R5 found", {63'd0, found}, 64'd1);
        chk("R5 offset", {56'd0, name_offset}, 64'd12);
        chk("R5 name", name_value, 64'h0102030405060708);
    endtask

    task automatic t_last_wins();
        clear_mem();
        mem[0] = 8'h8D; mem[1] = 8'h1B; mem[2] = 8'h00;
        mem[3] = 8'h01; mem[4] = 8'h02; mem[5] = 8'h00;
        mem[6] = 8'h3C; mem[7] = 8'h3C;
        mem[8] = 8'h3C; mem[9] = 8'h08; mem[10] = 8'h00;
        put8(11, 64'h5555AAAA5555AAAA);
        mem[19] = 8'h3C; mem[20] = 8'h08; mem[21] = 8'h00;
        put8(22, 64'h0F1E2D3C4B5A6978);
        mem[30] = 8'h78;
        run();
        chk("R7 offset", {56'd0, name_offset}, 64'd22);
        chk("R7 name", name_value, 64'h0F1E2D3C4B5A6978);
    endtask

    task automatic t_not_found();
        clear_mem();
        mem[0] = 8'h8D; mem[1] = 8'h0B; mem[2] = 8'h00;
        mem[3] = 8'h3D; mem[4] = 8'h08; mem[5] = 8'h00;
        put8(6, 64'h9999999999999999);
        run();
        chk("R8 found", {63'd0, found}, 64'd0);
        chk("R8 offset", {56'd0, name_offset}, 64'd0);
        chk("R8 name", name_value, 64'd0);
        chk("R11 full walk", 64'((last_cyc >= BUF) && (last_cyc <= BUF + NB + 6)), 64'd1);
    endtask

    task automatic t_boundary();
        clear_mem();
        mem[0] = 8'h08; mem[1] = 8'h10; mem[2] = 8'h18; mem[3] = 8'h20;
        mem[118] = 8'h8D; mem[119] = 8'h14; mem[120] = 8'h00;
        mem[121] = 8'h3C; mem[122] = 8'h08; mem[123] = 8'h00;
        mem[124] = 8'hD1; mem[125] = 8'hD2; mem[126] = 8'hD3; mem[127] = 8'hD4;
        run();
        chk("R9 offset", {56'd0, name_offset}, 64'd124);
        chk("R9 zero fill", name_value, 64'hD1D2D3D400000000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_end_marker();
        t_large_skip();
        t_override();
        t_last_wins();
        t_not_found();
        t_boundary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule